// File: doc/BRIEF.md
# Bridge ADC Serial Readout Controller

This block reads conversion results from an 18-bit delta-sigma bridge converter. The converter shares one line for two jobs. The line rests high and drops low to announce a finished conversion. After that, the same line carries the result bits, one per rising edge of a serial clock that this block drives. The controller detects the announcement by its falling edge. It then drives nineteen clock pulses and collects eighteen bits, most significant first. The nineteenth pulse makes the converter return the line to its high rest level, ready for the next cycle.

The result is a two's-complement code. It is presented as the raw 18-bit value and as a sign-extended 32-bit value, together with a one-cycle valid strobe. The first few conversions after reset or after waking from power-down are read and thrown away while the converter settles. The number thrown away is set by `SETTLE_COUNT`. Two static outputs, power-down and rate select, follow configuration inputs. `HALF_PERIOD` sets the number of system clocks in each half of the serial clock. It must be at least 3 so that a bit can pass the two-flop input synchronizer before it is sampled.

Top module: `bridge_adc_reader`

## Requirements
- R1: During and just after reset, `adc_sclk`, `data_valid`, `adc_pwrdn` and `adc_rate` are low, and `data_raw` and `data_ext` are zero.
- R2: `adc_pwrdn` and `adc_rate` take the values of `cfg_power_down` and `cfg_fast_rate` one clock later. On `adc_rate`, 0 selects 10 samples/s and 1 selects 80 samples/s.
- R3: A read starts only on a high-to-low change of the synchronized data line, seen while idle and powered up. A low level held from before, or held through power-down, never starts a read.
- R4: Each read drives exactly 19 rising edges on `adc_sclk`. Each high phase and each low phase lasts `HALF_PERIOD` system clocks.
- R5: Bits are sampled at the end of the high phase of pulses 1 to 18, most significant bit first. `data_raw` equals the 18 bits the converter presented.
- R6: `data_ext` is `data_raw` sign-extended from bit 17 to 32 bits. For example, 1FFFFh gives 0001FFFFh and 20000h gives FFFE0000h.
- R7: Each accepted conversion raises `data_valid` for exactly one system clock, and the line is idle (`adc_sclk` low) at that time.
- R8: The first `SETTLE_COUNT` completed reads after reset, or after any power-down, produce no `data_valid`.
- R9: While `cfg_power_down` is high, no read starts. A read in progress is abandoned, with `adc_sclk` low from the next clock and no `data_valid` for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_power_down | input | 1 | Request converter sleep; also gates reads |
| cfg_fast_rate | input | 1 | Rate choice: 0 = 10 samples/s, 1 = 80 samples/s |
| adc_ready_data | input | 1 | Combined ready/data line from the converter |
| adc_sclk | output | 1 | Serial clock to the converter |
| adc_pwrdn | output | 1 | Registered power-down to the converter |
| adc_rate | output | 1 | Registered rate select to the converter |
| data_valid | output | 1 | One-cycle strobe for a new result |
| data_raw | output | 18 | Raw two's-complement code |
| data_ext | output | 32 | Sign-extended result |

## Verification
Ready detection and the power-down gate can act in the same cycle. The data line falls while power-down is applied, and then power-down is released with the line still low. The bench holds the line low across the release and counts serial clock edges: a correct design gives none, because the low is stale. A second collision is made by raising power-down in the middle of a read. The bench checks that the clock stops, that no strobe follows, and that the discard count restarts, so the next settling reads are swallowed.

// File: rtl/bar_pkg.sv
// Package: shared constants and the read sequencer state type.
// Assumes one converter with an 18-bit code and a 19-pulse read.
package bar_pkg;
    localparam int CODE_W      = 18;
    localparam int EXT_W       = 32;
    localparam int READ_PULSES = CODE_W + 1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HIGH,
        ST_LOW,
        ST_DONE
    } rd_state_t;
endpackage

// File: rtl/bar_sync.sv
// Module: multi-stage synchronizer for an asynchronous single-bit input.
// Assumes the input is slow compared with clk. The reset value is chosen to
// match the idle level of the line.
module bar_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            // Purpose: one register stage of the chain.
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[i] <= RESET_VAL;
                    else        chain[i] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[i] <= RESET_VAL;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/bar_ready_detect.sv
// Module: edge-based detector for the converter's ready indication.
// Assumes line_s is already synchronized. The detector arms only after it
// sees the line high while the sequencer is idle and power is on, so a stale
// low level never counts as a new ready event.
module bar_ready_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic line_s,
    input  logic idle,
    input  logic power_down,
    output logic ready_evt
);
    logic armed;

    // Purpose: remember that an idle-high level was seen since the last read.
    always_ff @(posedge clk) begin
        if (!rst_n)                    armed <= 1'b0;
        else if (power_down || !idle)  armed <= 1'b0;
        else if (line_s)               armed <= 1'b1;
    end

    assign ready_evt = armed && !line_s && idle && !power_down;
endmodule

// File: rtl/bar_shift_engine.sv
// Module: serial clock generator and bit collector for one read.
// Assumes HALF_PERIOD >= 3 so that a bit presented at a rising edge has passed
// the two-flop synchronizer when it is sampled at the end of the high phase.
// abort has priority over every state and returns to idle with the clock low.
module bar_shift_engine
    import bar_pkg::*;
#(
    parameter int HALF_PERIOD = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic              line_s,
    output logic              sclk,
    output logic              idle,
    output logic              done,
    output logic [CODE_W-1:0] code
);
    localparam int HW = $clog2(HALF_PERIOD + 1);
    localparam int PW = $clog2(READ_PULSES + 1);
    localparam logic [HW-1:0] H_LAST   = HW'(HALF_PERIOD - 1);
    localparam logic [PW-1:0] P_FINAL  = PW'(READ_PULSES);
    localparam logic [PW-1:0] P_DATA   = PW'(CODE_W);

    rd_state_t         state;
    logic [HW-1:0]     hcnt;
    logic [PW-1:0]     pcnt;

    // Purpose: sequence the 19 clock pulses and shift in the data bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            sclk  <= 1'b0;
            hcnt  <= '0;
            pcnt  <= '0;
            code  <= '0;
        end else if (abort) begin
            state <= ST_IDLE;
            sclk  <= 1'b0;
            hcnt  <= '0;
            pcnt  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_HIGH;
                        sclk  <= 1'b1;
                        hcnt  <= '0;
                        pcnt  <= PW'(1);
                    end
                end
                ST_HIGH: begin
                    if (hcnt == H_LAST) begin
                        hcnt  <= '0;
                        sclk  <= 1'b0;
                        state <= ST_LOW;
                        if (pcnt <= P_DATA)
                            code <= {code[CODE_W-2:0], line_s};
                    end else begin
                        hcnt <= hcnt + 1'b1;
                    end
                end
                ST_LOW: begin
                    if (hcnt == H_LAST) begin
                        hcnt <= '0;
                        if (pcnt == P_FINAL) begin
                            state <= ST_DONE;
                        end else begin
                            sclk  <= 1'b1;
                            pcnt  <= pcnt + 1'b1;
                            state <= ST_HIGH;
                        end
                    end else begin
                        hcnt <= hcnt + 1'b1;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                    pcnt  <= '0;
                end
            endcase
        end
    end

    assign idle = (state == ST_IDLE);
    assign done = (state == ST_DONE);
endmodule

// File: rtl/bar_settle_gate.sv
// Module: drops the first conversions after wake-up and registers results.
// Assumes done is a one-cycle pulse that comes with a stable code. clear
// (power-down) restarts the discard count.
module bar_settle_gate
    import bar_pkg::*;
#(
    parameter int SETTLE_COUNT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              done,
    input  logic [CODE_W-1:0] code,
    output logic              data_valid,
    output logic [CODE_W-1:0] data_raw,
    output logic [EXT_W-1:0]  data_ext
);
    localparam int CW = $clog2(SETTLE_COUNT + 2);
    localparam logic [CW-1:0] C_LIMIT = CW'(SETTLE_COUNT);

    logic [CW-1:0] seen;

    // Purpose: count settling reads, then publish results with a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen       <= '0;
            data_valid <= 1'b0;
            data_raw   <= '0;
            data_ext   <= '0;
        end else begin
            data_valid <= 1'b0;
            if (clear) begin
                seen <= '0;
            end else if (done) begin
                if (seen < C_LIMIT) begin
                    seen <= seen + 1'b1;
                end else begin
                    data_valid <= 1'b1;
                    data_raw   <= code;
                    data_ext   <= {{(EXT_W-CODE_W){code[CODE_W-1]}}, code};
                end
            end
        end
    end
endmodule

// File: rtl/bridge_adc_reader.sv
// Module: top of the bridge converter readout controller.
// Assumes the converter line idles high and shifts a new bit on each rising
// serial clock edge. The configuration outputs are registered once.
module bridge_adc_reader
    import bar_pkg::*;
#(
    parameter int HALF_PERIOD  = 4,
    parameter int SETTLE_COUNT = 5,
    parameter int SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_power_down,
    input  logic              cfg_fast_rate,
    input  logic              adc_ready_data,
    output logic              adc_sclk,
    output logic              adc_pwrdn,
    output logic              adc_rate,
    output logic              data_valid,
    output logic [CODE_W-1:0] data_raw,
    output logic [EXT_W-1:0]  data_ext
);
    logic              line_s;
    logic              seq_idle;
    logic              seq_done;
    logic              ready_evt;
    logic [CODE_W-1:0] seq_code;

    bar_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (adc_ready_data),
        .dout  (line_s)
    );

    bar_ready_detect u_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_s     (line_s),
        .idle       (seq_idle),
        .power_down (cfg_power_down),
        .ready_evt  (ready_evt)
    );

    bar_shift_engine #(.HALF_PERIOD(HALF_PERIOD)) u_engine (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (ready_evt),
        .abort  (cfg_power_down),
        .line_s (line_s),
        .sclk   (adc_sclk),
        .idle   (seq_idle),
        .done   (seq_done),
        .code   (seq_code)
    );

    bar_settle_gate #(.SETTLE_COUNT(SETTLE_COUNT)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (cfg_power_down),
        .done       (seq_done),
        .code       (seq_code),
        .data_valid (data_valid),
        .data_raw   (data_raw),
        .data_ext   (data_ext)
    );

    // Purpose: register the static converter controls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adc_pwrdn <= 1'b0;
            adc_rate  <= 1'b0;
        end else begin
            adc_pwrdn <= cfg_power_down;
            adc_rate  <= cfg_fast_rate;
        end
    end
endmodule

// File: rtl/bar_checker.sv
// Module: property checker attached to the readout controller by bind.
// Assumes only the top-level ports; no internal state is read.
module bar_checker
    import bar_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_power_down,
    input logic              adc_sclk,
    input logic              adc_pwrdn,
    input logic              data_valid,
    input logic [CODE_W-1:0] data_raw,
    input logic [EXT_W-1:0]  data_ext
);
    AST_VALID_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |=> !data_valid); // R7
    AST_VALID_LINE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> !adc_sclk); // R7
    AST_EXT_MATCHES_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> (data_ext == {{(EXT_W-CODE_W){data_raw[CODE_W-1]}}, data_raw})); // R6
    AST_NO_CLOCK_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_power_down |=> !adc_sclk); // R9
    AST_NO_RESULT_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> !adc_pwrdn); // R9
endmodule

bind bridge_adc_reader bar_checker u_bar_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_power_down (cfg_power_down),
    .adc_sclk       (adc_sclk),
    .adc_pwrdn      (adc_pwrdn),
    .data_valid     (data_valid),
    .data_raw       (data_raw),
    .data_ext       (data_ext)
);

// File: tb/bridge_adc_reader_bench.sv
`timescale 1ns/1ps
module bridge_adc_reader_bench;
    localparam int HALF   = 4;
    localparam int SETTLE = 5;
    localparam int WAIT_READ = 19 * 2 * HALF + 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_power_down = 1'b0;
    logic        cfg_fast_rate = 1'b0;
    logic        line = 1'b1;
    logic        adc_sclk, adc_pwrdn, adc_rate, data_valid;
    logic [17:0] data_raw;
    logic [31:0] data_ext;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    bridge_adc_reader #(.HALF_PERIOD(HALF), .SETTLE_COUNT(SETTLE)) u_bridge_adc_reader (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_power_down (cfg_power_down),
        .cfg_fast_rate  (cfg_fast_rate),
        .adc_ready_data (line),
        .adc_sclk       (adc_sclk),
        .adc_pwrdn      (adc_pwrdn),
        .adc_rate       (adc_rate),
        .data_valid     (data_valid),
        .data_raw       (data_raw),
        .data_ext       (data_ext)
    );

    // Converter model: present a bit on each rising serial clock; go high after 18.
    logic [17:0] m_code = '0;
    int          m_cnt  = 19;
    always @(posedge adc_sclk) begin
        if (m_cnt < 18) line <= m_code[17 - m_cnt];
        else            line <= 1'b1;
        m_cnt <= m_cnt + 1;
    end

    // Monitor, sampled away from the active edge.
    int          rises = 0;
    int          valid_cnt = 0;
    int          hi_run = 0;
    int          last_hi = 0;
    logic        prev_sclk = 1'b0;
    logic [17:0] got_raw = '0;
    logic [31:0] got_ext = '0;
    always @(negedge clk) begin
        if (adc_sclk && !prev_sclk) rises++;
        if (adc_sclk) hi_run++;
        else if (prev_sclk) begin
            last_hi = hi_run;
            hi_run  = 0;
        end
        if (data_valid) begin
            valid_cnt++;
            got_raw = data_raw;
            got_ext = data_ext;
        end
        prev_sclk = adc_sclk;
    end

    // Watchdog: an overlong run is a failure and still reports.
    int cycles = 0;
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<=150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic convert(input logic [17:0] code);
        m_code    = code;
        m_cnt     = 0;
        rises     = 0;
        valid_cnt = 0;
        @(negedge clk);
        line = 1'b0;
        wait_cycles(WAIT_READ);
    endtask

    // Vector table: {18-bit code, expected 32-bit sign-extended value}.
    localparam logic [49:0] VEC [6] = '{
        {18'h1FFFF, 32'h0001_FFFF},
        {18'h20000, 32'hFFFE_0000},
        {18'h00000, 32'h0000_0000},
        {18'h3FFFF, 32'hFFFF_FFFF},
        {18'h2AAAA, 32'hFFFE_AAAA},
        {18'h15555, 32'h0001_5555}
    };

    initial begin
        wait_cycles(5);
        // R1 reset state
        check(adc_sclk == 0 && data_valid == 0, "R1 sclk/valid", {30'd0, adc_sclk, data_valid}, 0);
        check(data_raw == 0 && data_ext == 0, "R1 data", data_ext, 0);
        check(adc_pwrdn == 0 && adc_rate == 0, "R1 cfg outs", {30'd0, adc_pwrdn, adc_rate}, 0);
        rst_n = 1'b1;
        wait_cycles(3);
        check(adc_sclk == 0 && data_valid == 0, "R1 after release", {31'd0, adc_sclk}, 0);

        // R2 rate select follows config (1 = 80 samples/s)
        cfg_fast_rate = 1'b1;
        wait_cycles(2);
        check(adc_rate == 1'b1, "R2 rate high", {31'd0, adc_rate}, 1);
        cfg_fast_rate = 1'b0;
        wait_cycles(2);
        check(adc_rate == 1'b0, "R2 rate low", {31'd0, adc_rate}, 0);

        // R8 settling reads discarded; R4 pulse count and width
        for (int i = 0; i < SETTLE; i++) begin
            convert(18'h12345);
            check(rises == 19, "R4 pulses per read", rises, 19);
            check(valid_cnt == 0, "R8 settle discard", valid_cnt, 0);
        end
        check(last_hi == HALF, "R4 high phase width", last_hi, HALF);

        // Table walk: R5 raw code, R6 sign extension, R7 single strobe
        for (int v = 0; v < 6; v++) begin
            convert(VEC[v][49:32]);
            check(valid_cnt == 1, "R7 one strobe", valid_cnt, 1);
            check(got_raw == VEC[v][49:32], "R5 raw code", {14'd0, got_raw}, {14'd0, VEC[v][49:32]});
            check(got_ext == VEC[v][31:0], "R6 sign ext", got_ext, VEC[v][31:0]);
            check(rises == 19, "R4 pulses per read", rises, 19);
        end

        // R9 no read while powered down; R3 stale low after release
        cfg_power_down = 1'b1;
        wait_cycles(2);
        check(adc_pwrdn == 1'b1, "R2 pwrdn follows", {31'd0, adc_pwrdn}, 1);
        m_cnt = 0;
        rises = 0;
        line  = 1'b0;
        wait_cycles(50);
        check(rises == 0, "R9 no read asleep", rises, 0);
        cfg_power_down = 1'b0;
        wait_cycles(100);
        check(rises == 0, "R3 stale low ignored", rises, 0);
        line  = 1'b1;
        m_cnt = 19;
        wait_cycles(5);

        // R8 discard count restarts after power-down
        for (int i = 0; i < SETTLE; i++) begin
            convert(18'h0ABCD);
            check(valid_cnt == 0, "R8 settle after wake", valid_cnt, 0);
        end
        convert(18'h2AAAA);
        check(valid_cnt == 1 && got_raw == 18'h2AAAA, "R3 fresh edge read", {14'd0, got_raw}, 32'h2AAAA);

        // R9 abort mid-read
        m_code    = 18'h1FFFF;
        m_cnt     = 0;
        rises     = 0;
        valid_cnt = 0;
        line      = 1'b0;
        wait_cycles(60);
        cfg_power_down = 1'b1;
        wait_cycles(2);
        check(adc_sclk == 1'b0, "R9 clock stopped", {31'd0, adc_sclk}, 0);
        begin
            int frozen;
            frozen = rises;
            wait_cycles(60);
            check(rises == frozen && rises < 19, "R9 no more pulses", rises, frozen);
        end
        check(valid_cnt == 0, "R9 no strobe on abort", valid_cnt, 0);
        cfg_power_down = 1'b0;
        line  = 1'b1;
        m_cnt = 19;
        wait_cycles(10);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule